// File: doc/BRIEF.md
# Calibrated One-Second Divider

This block turns a stream of oscillator enables, nominally 32,768 per second, into a single-cycle one-second tick for a calendar counter. It does not use a trimmed crystal. Instead it corrects the rate digitally. Within a repeating 64-minute window, it shortens or lengthens one second in each of the first 2×N minutes by a fixed number of oscillator cycles. N is a 5-bit calibration magnitude, and a sign input chooses whether the clock gains or loses.

A separate free-running divider produces a 512 Hz square wave for frequency measurement. It runs from the same oscillator enable, and the calibration setting never touches it. A stop input freezes the whole divider at zero, and a test-enable input gates the square wave onto its output.

The system clock runs much faster than the oscillator. The oscillator arrives as a one-cycle enable (`oscTick`), and every count advances only on that enable.

Top module: `cal_divider`

## Requirements
- R1: With calMag = 0, every second lasts exactly OSC_HZ oscillator enables, and `secTick` is high for exactly one clock cycle at the end of each second.
- R2: With calSign = 1 and calMag = N > 0, second index 0 of each minute index below 2×N lasts OSC_HZ − POS_ADJ enables (default 32,768 − 256).
- R3: With calSign = 0 and calMag = N > 0, second index 0 of each minute index below 2×N lasts OSC_HZ + NEG_ADJ enables (default 32,768 + 128).
- R4: Every other second lasts OSC_HZ enables. This covers all other seconds of a modified minute and every second of minute indices from 2×N up to MIN_PER_CYCLE − 1. After MIN_PER_CYCLE minutes the window restarts at minute index 0.
- R5: Counting advances only on cycles where `oscTick` is high. With one enable every two clock cycles, a nominal second spans 2×OSC_HZ clock cycles.
- R6: While `stopBit` is 1, `secTick` stays 0 and `testWave` stays 0. On release, the divider restarts at count zero, second index 0 and minute index 0 of the correction window.
- R7: With `ftEnable` = 1 and `stopBit` = 0, `testWave` toggles every OSC_HZ/1024 oscillator enables, which gives 512 Hz. A shortened or lengthened second does not change this spacing.
- R8: With `ftEnable` = 0, `testWave` is 0.
- R9: While `rstN` is low, `secTick` and `testWave` are 0. After reset, the first second starts at count zero in minute index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle enable per oscillator period |
| calMag | input | CAL_W (5) | Calibration magnitude N, 0 to 31 |
| calSign | input | 1 | 1 = gain (shorten seconds), 0 = lose (lengthen seconds) |
| stopBit | input | 1 | 1 holds the divider and correction window at zero |
| ftEnable | input | 1 | 1 drives the 512 Hz test wave onto `testWave` |
| secTick | output | 1 | One-cycle pulse at the end of each second |
| testWave | output | 1 | 512 Hz square wave, gated by `ftEnable` and `stopBit` |

## Verification
A second or minute index that is off by one moves the corrected second to a different position in the pulse train. This shows up as an interval between two `secTick` pulses that has the wrong length, at the latest one correction window after reset. A wrong terminal count or adjustment amount appears within the first second of a modified minute. Stop and restart faults appear in the first interval after release, because that interval must be the corrected second of minute zero. A test divider that is coupled to the second counter breaks the regular toggle spacing of `testWave` at the first shortened second.

// File: rtl/cal_div_pkg.sv
package cal_div_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic holdZero;  // stop: clear every counter
    logic endSec;    // last enable of the current second
  } divStrobe_t;
endpackage

// File: rtl/cal_div_ctrl.sv
module cal_div_ctrl
  import cal_div_pkg::*;
#(
  parameter int OSC_HZ        = 32768,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int POS_ADJ       = 256,
  parameter int NEG_ADJ       = 128,
  parameter int CAL_W         = 5,
  localparam int CNT_W        = $clog2(OSC_HZ + NEG_ADJ),
  localparam int SEC_W        = $clog2(SEC_PER_MIN),
  localparam int MIN_W        = $clog2(MIN_PER_CYCLE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             stopBit,
  input  logic [CAL_W-1:0] calMag,
  input  logic             calSign,
  input  logic [CNT_W-1:0] oscCount,
  output divStrobe_t       ctl
);
  localparam logic [CNT_W-1:0] NOM_LAST   = CNT_W'(OSC_HZ - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(OSC_HZ - POS_ADJ - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(OSC_HZ + NEG_ADJ - 1);

  logic [SEC_W-1:0] secIdx;
  logic [MIN_W-1:0] minIdx;
  logic             modSecond;
  logic [CNT_W-1:0] lastCount;

  always_comb begin
    modSecond  = (secIdx == '0) && (32'(minIdx) < 32'({calMag, 1'b0}));
    lastCount  = modSecond ? (calSign ? SHORT_LAST : LONG_LAST) : NOM_LAST;
    ctl.holdZero = stopBit;
    ctl.endSec   = oscTick && !stopBit && (oscCount == lastCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN || stopBit) begin
      secIdx <= '0;
      minIdx <= '0;
    end else if (ctl.endSec) begin
      if (32'(secIdx) == SEC_PER_MIN - 1) begin
        secIdx <= '0;
        minIdx <= (32'(minIdx) == MIN_PER_CYCLE - 1) ? '0 : minIdx + 1'b1;
      end else begin
        secIdx <= secIdx + 1'b1;
      end
    end
  end

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscCount <= LONG_LAST);
  // R4
  index_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(secIdx) < SEC_PER_MIN) && (32'(minIdx) < MIN_PER_CYCLE));
  // R6
  stop_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |=> (secIdx == '0) && (minIdx == '0) && (oscCount == '0));
endmodule

// File: rtl/cal_div_datapath.sv
module cal_div_datapath
  import cal_div_pkg::*;
#(
  parameter int OSC_HZ  = 32768,
  parameter int NEG_ADJ = 128,
  localparam int CNT_W     = $clog2(OSC_HZ + NEG_ADJ),
  localparam int TEST_HALF = OSC_HZ / 1024,
  localparam int TEST_W    = $clog2(TEST_HALF) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             ftEnable,
  input  divStrobe_t       ctl,
  output logic [CNT_W-1:0] oscCount,
  output logic             secTick,
  output logic             testWave
);
  logic [TEST_W-1:0] testDiv;
  logic              waveReg;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.holdZero) begin
      oscCount <= '0;
      secTick  <= 1'b0;
    end else begin
      secTick <= ctl.endSec;
      if (ctl.endSec)   oscCount <= '0;
      else if (oscTick) oscCount <= oscCount + 1'b1;
    end
  end

  // free-running test divider, blind to calibration
  always_ff @(posedge clk) begin
    if (!rstN || ctl.holdZero) begin
      testDiv <= '0;
      waveReg <= 1'b0;
    end else if (oscTick) begin
      if (32'(testDiv) == TEST_HALF - 1) begin
        testDiv <= '0;
        waveReg <= ~waveReg;
      end else begin
        testDiv <= testDiv + 1'b1;
      end
    end
  end

  assign testWave = waveReg & ftEnable & ~ctl.holdZero;

  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);
  // R5
  wave_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oscTick && !ctl.holdZero) |=> $stable(waveReg));
  // R6
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdZero |=> !secTick && !waveReg);
endmodule

// File: rtl/cal_divider.sv
module cal_divider
  import cal_div_pkg::*;
#(
  parameter int OSC_HZ        = 32768,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int POS_ADJ       = 256,
  parameter int NEG_ADJ       = 128,
  parameter int CAL_W         = 5,
  localparam int CNT_W        = $clog2(OSC_HZ + NEG_ADJ)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic [CAL_W-1:0] calMag,
  input  logic             calSign,
  input  logic             stopBit,
  input  logic             ftEnable,
  output logic             secTick,
  output logic             testWave
);
  divStrobe_t       ctl;
  logic [CNT_W-1:0] oscCount;

  cal_div_ctrl #(
    .OSC_HZ(OSC_HZ), .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE),
    .POS_ADJ(POS_ADJ), .NEG_ADJ(NEG_ADJ), .CAL_W(CAL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .stopBit(stopBit),
    .calMag(calMag), .calSign(calSign), .oscCount(oscCount), .ctl(ctl)
  );

  cal_div_datapath #(
    .OSC_HZ(OSC_HZ), .NEG_ADJ(NEG_ADJ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .ftEnable(ftEnable),
    .ctl(ctl), .oscCount(oscCount), .secTick(secTick), .testWave(testWave)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !secTick && !testWave);
endmodule

// File: tb/cal_divider_tb.sv
`timescale 1ns/1ps
module cal_divider_tb;
  localparam int OSC_HZ = 1024, SPM = 4, MPC = 8, PADJ = 64, NADJ = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] calMag = '0;
  logic calSign = 1'b0, stopBit = 1'b0, ftEnable = 1'b0;
  logic secTick, testWave, oscTick;
  int   oscMode = 0;   // 0 off, 1 every cycle, 2 every other cycle
  logic phase = 1'b0;
  int   checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;
  always @(negedge clk) phase <= ~phase;
  assign oscTick = (oscMode == 1) || (oscMode == 2 && phase);

  cal_divider #(.OSC_HZ(OSC_HZ), .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC),
                .POS_ADJ(PADJ), .NEG_ADJ(NADJ)) u_dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .calMag(calMag),
    .calSign(calSign), .stopBit(stopBit), .ftEnable(ftEnable),
    .secTick(secTick), .testWave(testWave));

  task automatic report(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int expLen(input int g, input int n, input bit pos);
    if ((g % SPM) == 0 && ((g / SPM) % MPC) < 2 * n)
      return pos ? OSC_HZ - PADJ : OSC_HZ + NADJ;
    return OSC_HZ;
  endfunction

  task automatic doReset();
    oscMode = 0; stopBit = 0;
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic measureSec(output int len);
    len = 0;
    do begin
      @(negedge clk); len++;
    end while (!secTick && len < 5000);
  endtask

  task automatic runWindow(input string req, input int n, input bit pos, input int secs);
    int len, bad = 0;
    doReset(); calMag = 5'(n); calSign = pos; oscMode = 1;
    for (int g = 0; g < secs; g++) begin
      measureSec(len);
      if (len != expLen(g, n, pos)) begin
        bad++;
        $display("FAIL %s: second %0d got %0d expected %0d", req, g, len, expLen(g, n, pos));
      end
    end
    checks++; if (bad != 0) fails++;
  endtask

  task automatic testReset();   // R9
    ftEnable = 1; oscMode = 1; @(negedge clk); rstN = 0;
    repeat (4) begin
      @(negedge clk);
      report("R9 secTick", secTick, 0);
      report("R9 testWave", testWave, 0);
    end
    ftEnable = 0;
  endtask

  task automatic testNominal();   // R1
    int len, wide = 0;
    doReset(); calMag = 0; oscMode = 1;
    for (int i = 0; i < 5; i++) begin
      measureSec(len); report("R1 nominal second", len, OSC_HZ);
      @(negedge clk); if (secTick) wide++;
      measureSec(len); report("R1 nominal second", len + 1, OSC_HZ);
    end
    report("R1 pulse width", wide, 0);
  endtask

  task automatic testGapped();   // R5
    int len;
    doReset(); calMag = 0; oscMode = 2;
    measureSec(len);
    for (int i = 0; i < 2; i++) begin
      measureSec(len); report("R5 gapped second", len, 2 * OSC_HZ);
    end
  endtask

  task automatic testStop();   // R6
    int len, badTick = 0, badWave = 0;
    doReset(); calMag = 1; calSign = 1; ftEnable = 1; oscMode = 1;
    measureSec(len);
    repeat (300) @(negedge clk);
    stopBit = 1;
    @(negedge clk);
    repeat (3000) begin
      @(negedge clk);
      if (secTick) badTick++;
      if (testWave) badWave++;
    end
    report("R6 no tick while stopped", badTick, 0);
    report("R6 wave low while stopped", badWave, 0);
    stopBit = 0;
    measureSec(len); report("R6 restart at corrected second", len, OSC_HZ - PADJ);
    measureSec(len); report("R6 restart next second", len, OSC_HZ);
    ftEnable = 0;
  endtask

  task automatic testWaveOut();   // R7, R8
    int badToggle = 0, ones = 0;
    logic prev;
    doReset(); calMag = 3; calSign = 1; ftEnable = 1; oscMode = 1;
    @(negedge clk); prev = testWave;
    repeat (2500) begin   // spans a shortened second
      @(negedge clk);
      if (testWave == prev) badToggle++;  // OSC_HZ/1024 = 1 enable per half period
      prev = testWave;
    end
    report("R7 toggle every enable", badToggle, 0);
    ftEnable = 0;
    repeat (200) begin
      @(negedge clk); if (testWave) ones++;
    end
    report("R8 gated off", ones, 0);
  endtask

  initial begin
    testReset();
    testNominal();
    testGapped();
    runWindow("R2", 1, 1'b1, 34);   // also R4 wrap at second 32
    runWindow("R3", 2, 1'b0, 34);   // also R4
    runWindow("R4", 3, 1'b1, 34);
    testStop();
    testWaveOut();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule